// File: doc/BRIEF.md
# Configuration Cycle Address Router

This block holds the 32-bit configuration address register that the host reaches through I/O port 0CF8h. The host first writes a bus, device, function and register selection into that register. It then touches the data window at 0CFCh–0CFFh. Each window access is steered to one of three places: the hub's own internal devices, the downstream link, or the graphics port. For the two external destinations the block also picks a Type 0 or Type 1 cycle. The choice compares the stored bus number against the secondary and subordinate bus numbers of the graphics bridge.

The register is claimed only on a full-dword access. A byte or word access to the address port is handed downstream as an ordinary I/O cycle. So is any data-window access made while the enable bit is clear.

Each routing result comes out as a one-cycle strobe. The strobe carries the destination, the cycle type and the selection fields that the forwarding logic needs.

Top module: `cfg_route_top`

## Requirements
- R1: After reset the address register reads 00000000h, and neither `route_valid` nor `io_pass` is high.
- R2: A write to 0CF8h with all four byte enables set stores the written value with bits 30:24 and 1:0 forced to zero, so writing FFFFFFFFh reads back 80FFFFFCh. A read with all four enables returns the register on `io_rdata` in the same cycle. The field layout is: bit 31 enable, bits 23:16 bus, bits 15:11 device, bits 10:8 function, bits 7:2 register.
- R3: An access to 0CF8h with some, but not all, byte enables set leaves the register unchanged. Such a read returns zero. The access raises `io_pass` one cycle later, with `pass_addr` and `pass_be` equal to the access.
- R4: With enable set and bus 0, device numbers 0, 1, 2 and 7 route to the internal target, encoded as `route_tgt` = 0 with `route_type1` = 0.
- R5: With enable set and bus 0, any other device number routes to the downstream link (`route_tgt` = 1) as Type 0.
- R6: With enable set and a non-zero bus equal to `sec_bus`, the access routes to the graphics port (`route_tgt` = 2) as Type 0.
- R7: With enable set and a non-zero bus above `sec_bus` and at most `sub_bus`, the access routes to the graphics port as Type 1. This includes the case where the bus equals `sub_bus`.
- R8: With enable set and a non-zero bus outside the `sec_bus` to `sub_bus` range, the access routes to the downstream link as Type 1, and `route_bus` carries the bus number.
- R9: With enable clear, a data-window access produces no `route_valid`. Instead it raises `io_pass` one cycle later.
- R10: A data-window access with enable set raises `route_valid` for exactly the next cycle. In that cycle `route_bus`, `route_dev`, `route_fn` and `route_reg` equal the stored fields.
- R11: An access to any address other than 0CF8h–0CFFh changes nothing. It does not alter the register, and it raises neither `route_valid` nor `io_pass`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| io_valid | input | 1 | One-cycle I/O access strobe |
| io_write | input | 1 | 1 = write, 0 = read |
| io_addr | input | 16 | I/O byte address |
| io_be | input | 4 | Byte enables of the access |
| io_wdata | input | 32 | Write data |
| io_rdata | output | 32 | Read data, valid in the access cycle |
| sec_bus | input | 8 | Bridge secondary bus number |
| sub_bus | input | 8 | Bridge subordinate bus number |
| route_valid | output | 1 | Routing result strobe |
| route_tgt | output | 2 | 0 internal, 1 downstream link, 2 graphics port |
| route_type1 | output | 1 | 1 = Type 1 cycle, 0 = Type 0 |
| route_bus | output | 8 | Bus number forwarded |
| route_dev | output | 5 | Device number forwarded |
| route_fn | output | 3 | Function number forwarded |
| route_reg | output | 6 | Dword register number forwarded |
| io_pass | output | 1 | Plain I/O forward strobe |
| pass_addr | output | 16 | Address of the forwarded I/O cycle |
| pass_be | output | 4 | Byte enables of the forwarded I/O cycle |

## Verification
Read data is due in the same cycle as the read strobe, so the bench samples `io_rdata` while the strobe is still high, before the capturing edge. Routing results and pass-through strobes appear one register later. After the edge that takes an access, the bench samples them at the following falling edge. One more cycle on, it samples again to confirm that the strobe has dropped. A register write counts as complete at that same edge. Every later read-back and every routing lookup depends only on that edge having passed.

// File: rtl/cfg_route_pkg.sv
package cfg_route_pkg;

  localparam int CFG_W  = 32;
  localparam int BUS_W  = 8;
  localparam int DEV_W  = 5;
  localparam int FN_W   = 3;
  localparam int REG_W  = 6;

  localparam int EN_BIT  = 31;
  localparam int BUS_LSB = 16;
  localparam int DEV_LSB = 11;
  localparam int FN_LSB  = 8;
  localparam int REG_LSB = 2;

  localparam logic [CFG_W-1:0] CFG_WMASK = 32'h80FF_FFFC;

  typedef enum logic [1:0] {
    TGT_INT  = 2'd0,
    TGT_LINK = 2'd1,
    TGT_GFX  = 2'd2
  } tgt_e;

  typedef struct packed {
    tgt_e tgt;
    logic type1;
  } route_t;

  function automatic logic dev_is_local(input logic [DEV_W-1:0] dev);
    return (dev < DEV_W'(3)) || (dev == DEV_W'(7));
  endfunction

  function automatic logic bus_below_bridge(input logic [BUS_W-1:0] bus,
                                            input logic [BUS_W-1:0] sec,
                                            input logic [BUS_W-1:0] sub);
    return (bus > sec) && (bus <= sub);
  endfunction

  function automatic route_t pick_route(input logic [BUS_W-1:0] bus,
                                        input logic [DEV_W-1:0] dev,
                                        input logic [BUS_W-1:0] sec,
                                        input logic [BUS_W-1:0] sub);
    route_t r;
    if (bus == '0) begin
      r.tgt   = dev_is_local(dev) ? TGT_INT : TGT_LINK;
      r.type1 = 1'b0;
    end else if (bus == sec) begin
      r.tgt   = TGT_GFX;
      r.type1 = 1'b0;
    end else if (bus_below_bridge(bus, sec, sub)) begin
      r.tgt   = TGT_GFX;
      r.type1 = 1'b1;
    end else begin
      r.tgt   = TGT_LINK;
      r.type1 = 1'b1;
    end
    return r;
  endfunction

endpackage

// File: rtl/cfg_port_decode.sv
module cfg_port_decode #(
  parameter int              ADDR_W    = 16,
  parameter int              BE_W      = 4,
  parameter logic [ADDR_W-1:0] ADDR_PORT = 16'h0CF8,
  parameter logic [ADDR_W-1:0] DATA_PORT = 16'h0CFC
) (
  input  logic              io_valid,
  input  logic [ADDR_W-1:0] io_addr,
  input  logic [BE_W-1:0]   io_be,
  output logic              addr_full,
  output logic              addr_part,
  output logic              win_hit
);
  localparam int LANE_BITS = $clog2(BE_W);

  logic at_addr_port;
  logic in_window;
  logic any_be;
  logic all_be;

  always_comb begin
    at_addr_port = (io_addr == ADDR_PORT);
    in_window    = (io_addr[ADDR_W-1:LANE_BITS] == DATA_PORT[ADDR_W-1:LANE_BITS]);
    any_be       = |io_be;
    all_be       = &io_be;
    addr_full    = io_valid && at_addr_port && all_be;
    addr_part    = io_valid && at_addr_port && any_be && !all_be;
    win_hit      = io_valid && in_window && any_be;
  end
endmodule

// File: rtl/cfg_addr_reg.sv
module cfg_addr_reg
  import cfg_route_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [CFG_W-1:0] wdata,
  output logic [CFG_W-1:0] q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     q <= '0;
    else if (wr_en) q <= wdata & CFG_WMASK;
  end
endmodule

// File: rtl/cfg_route_decide.sv
module cfg_route_decide
  import cfg_route_pkg::*;
(
  input  logic [CFG_W-1:0] cfg_q,
  input  logic [BUS_W-1:0] sec_bus,
  input  logic [BUS_W-1:0] sub_bus,
  output route_t           route,
  output logic [BUS_W-1:0] f_bus,
  output logic [DEV_W-1:0] f_dev,
  output logic [FN_W-1:0]  f_fn,
  output logic [REG_W-1:0] f_reg
);
  always_comb begin
    f_bus = cfg_q[BUS_LSB +: BUS_W];
    f_dev = cfg_q[DEV_LSB +: DEV_W];
    f_fn  = cfg_q[FN_LSB  +: FN_W];
    f_reg = cfg_q[REG_LSB +: REG_W];
    route = pick_route(f_bus, f_dev, sec_bus, sub_bus);
  end
endmodule

// File: rtl/cfg_route_out.sv
module cfg_route_out
  import cfg_route_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int BE_W   = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              route_fire,
  input  route_t            route_in,
  input  logic [BUS_W-1:0]  bus_in,
  input  logic [DEV_W-1:0]  dev_in,
  input  logic [FN_W-1:0]   fn_in,
  input  logic [REG_W-1:0]  reg_in,
  input  logic              pass_fire,
  input  logic [ADDR_W-1:0] addr_in,
  input  logic [BE_W-1:0]   be_in,
  output logic              route_valid,
  output logic [1:0]        route_tgt,
  output logic              route_type1,
  output logic [BUS_W-1:0]  route_bus,
  output logic [DEV_W-1:0]  route_dev,
  output logic [FN_W-1:0]   route_fn,
  output logic [REG_W-1:0]  route_reg,
  output logic              io_pass,
  output logic [ADDR_W-1:0] pass_addr,
  output logic [BE_W-1:0]   pass_be
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      route_valid <= 1'b0;
      route_tgt   <= '0;
      route_type1 <= 1'b0;
      route_bus   <= '0;
      route_dev   <= '0;
      route_fn    <= '0;
      route_reg   <= '0;
    end else begin
      route_valid <= route_fire;
      if (route_fire) begin
        route_tgt   <= route_in.tgt;
        route_type1 <= route_in.type1;
        route_bus   <= bus_in;
        route_dev   <= dev_in;
        route_fn    <= fn_in;
        route_reg   <= reg_in;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      io_pass   <= 1'b0;
      pass_addr <= '0;
      pass_be   <= '0;
    end else begin
      io_pass <= pass_fire;
      if (pass_fire) begin
        pass_addr <= addr_in;
        pass_be   <= be_in;
      end
    end
  end
endmodule

// File: rtl/cfg_route_top.sv
module cfg_route_top
  import cfg_route_pkg::*;
#(
  parameter int                ADDR_W    = 16,
  parameter int                BE_W      = 4,
  parameter logic [ADDR_W-1:0] ADDR_PORT = 16'h0CF8,
  parameter logic [ADDR_W-1:0] DATA_PORT = 16'h0CFC
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              io_valid,
  input  logic              io_write,
  input  logic [15:0]       io_addr,
  input  logic [3:0]        io_be,
  input  logic [31:0]       io_wdata,
  output logic [31:0]       io_rdata,
  input  logic [7:0]        sec_bus,
  input  logic [7:0]        sub_bus,
  output logic              route_valid,
  output logic [1:0]        route_tgt,
  output logic              route_type1,
  output logic [7:0]        route_bus,
  output logic [4:0]        route_dev,
  output logic [2:0]        route_fn,
  output logic [5:0]        route_reg,
  output logic              io_pass,
  output logic [15:0]       pass_addr,
  output logic [3:0]        pass_be
);
  logic             addr_full;
  logic             addr_part;
  logic             win_hit;
  logic             cfg_en;
  logic             reg_wr;
  logic             reg_rd;
  logic             route_fire;
  logic             pass_fire;
  logic [CFG_W-1:0] cfg_q;
  route_t           route_c;
  logic [BUS_W-1:0] f_bus;
  logic [DEV_W-1:0] f_dev;
  logic [FN_W-1:0]  f_fn;
  logic [REG_W-1:0] f_reg;

  cfg_port_decode #(
    .ADDR_W(ADDR_W), .BE_W(BE_W), .ADDR_PORT(ADDR_PORT), .DATA_PORT(DATA_PORT)
  ) u_dec (
    .io_valid (io_valid),
    .io_addr  (io_addr),
    .io_be    (io_be),
    .addr_full(addr_full),
    .addr_part(addr_part),
    .win_hit  (win_hit)
  );

  always_comb begin
    reg_wr     = addr_full && io_write;
    reg_rd     = addr_full && !io_write;
    cfg_en     = cfg_q[EN_BIT];
    route_fire = win_hit && cfg_en;
    pass_fire  = addr_part || (win_hit && !cfg_en);
    io_rdata   = reg_rd ? cfg_q : '0;
  end

  cfg_addr_reg u_reg (
    .clk  (clk),
    .rst_n(rst_n),
    .wr_en(reg_wr),
    .wdata(io_wdata),
    .q    (cfg_q)
  );

  cfg_route_decide u_decide (
    .cfg_q  (cfg_q),
    .sec_bus(sec_bus),
    .sub_bus(sub_bus),
    .route  (route_c),
    .f_bus  (f_bus),
    .f_dev  (f_dev),
    .f_fn   (f_fn),
    .f_reg  (f_reg)
  );

  cfg_route_out #(.ADDR_W(ADDR_W), .BE_W(BE_W)) u_out (
    .clk        (clk),
    .rst_n      (rst_n),
    .route_fire (route_fire),
    .route_in   (route_c),
    .bus_in     (f_bus),
    .dev_in     (f_dev),
    .fn_in      (f_fn),
    .reg_in     (f_reg),
    .pass_fire  (pass_fire),
    .addr_in    (io_addr),
    .be_in      (io_be),
    .route_valid(route_valid),
    .route_tgt  (route_tgt),
    .route_type1(route_type1),
    .route_bus  (route_bus),
    .route_dev  (route_dev),
    .route_fn   (route_fn),
    .route_reg  (route_reg),
    .io_pass    (io_pass),
    .pass_addr  (pass_addr),
    .pass_be    (pass_be)
  );
endmodule

// File: rtl/cfg_route_chk.sv
module cfg_route_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        addr_part,
  input logic        win_hit,
  input logic        cfg_en,
  input logic [31:0] cfg_q,
  input logic        route_valid,
  input logic [1:0]  route_tgt,
  input logic        route_type1,
  input logic [7:0]  route_bus,
  input logic [7:0]  sec_bus,
  input logic        io_pass
);
  p_strobe_next_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (win_hit && cfg_en) |=> route_valid);

  p_no_route_when_off_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (win_hit && !cfg_en) |=> (io_pass && !route_valid));

  p_partial_keeps_reg_r3: assert property (@(posedge clk) disable iff (!rst_n)
    addr_part |=> $stable(cfg_q));

  p_internal_on_bus0_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (route_valid && route_tgt == 2'd0) |-> (route_bus == 8'd0 && !route_type1));

  p_gfx_type0_sec_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (route_valid && route_tgt == 2'd2 && !route_type1) |-> route_bus == $past(sec_bus));

  p_link_type1_nonzero_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (route_valid && route_tgt == 2'd1 && route_type1) |-> route_bus != 8'd0);

  p_one_outcome_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !(route_valid && io_pass));
endmodule

bind cfg_route_top cfg_route_chk u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .addr_part  (addr_part),
  .win_hit    (win_hit),
  .cfg_en     (cfg_en),
  .cfg_q      (cfg_q),
  .route_valid(route_valid),
  .route_tgt  (route_tgt),
  .route_type1(route_type1),
  .route_bus  (route_bus),
  .sec_bus    (sec_bus),
  .io_pass    (io_pass)
);

// File: tb/cfg_route_top_tb.sv
module cfg_route_top_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        io_valid = 1'b0;
  logic        io_write = 1'b0;
  logic [15:0] io_addr = '0;
  logic [3:0]  io_be = '0;
  logic [31:0] io_wdata = '0;
  logic [31:0] io_rdata;
  logic [7:0]  sec_bus = '0;
  logic [7:0]  sub_bus = '0;
  logic        route_valid;
  logic [1:0]  route_tgt;
  logic        route_type1;
  logic [7:0]  route_bus;
  logic [4:0]  route_dev;
  logic [2:0]  route_fn;
  logic [5:0]  route_reg;
  logic        io_pass;
  logic [15:0] pass_addr;
  logic [3:0]  pass_be;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  cfg_route_top u_dut (.*);

  // vector: bus[31:24] dev[23:19] sec[18:11] sub[10:3] tgt[2:1] type1[0]
  localparam int NV = 12;
  localparam logic [31:0] VEC [NV] = '{
    {8'd0,  5'd0, 8'd5, 8'd9, 2'd0, 1'b0},   // R4
    {8'd0,  5'd2, 8'd5, 8'd9, 2'd0, 1'b0},   // R4
    {8'd0,  5'd3, 8'd5, 8'd9, 2'd1, 1'b0},   // R5
    {8'd0,  5'd7, 8'd5, 8'd9, 2'd0, 1'b0},   // R4
    {8'd0,  5'd8, 8'd5, 8'd9, 2'd1, 1'b0},   // R5
    {8'd5,  5'd0, 8'd5, 8'd9, 2'd2, 1'b0},   // R6
    {8'd6,  5'd4, 8'd5, 8'd9, 2'd2, 1'b1},   // R7
    {8'd9,  5'd1, 8'd5, 8'd9, 2'd2, 1'b1},   // R7 upper edge
    {8'd10, 5'd6, 8'd5, 8'd9, 2'd1, 1'b1},   // R8
    {8'd4,  5'd9, 8'd5, 8'd9, 2'd1, 1'b1},   // R8 below
    {8'd1,  5'd3, 8'd1, 8'd1, 2'd2, 1'b0},   // R6 sec==sub
    {8'd2,  5'd3, 8'd1, 8'd1, 2'd1, 1'b1}    // R8
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Drives one access at a falling edge; returns at the next falling edge,
  // one edge after the access was taken.
  task automatic io_op(input logic wr, input logic [15:0] a, input logic [3:0] be,
                       input logic [31:0] d);
    @(negedge clk);
    io_valid = 1'b1; io_write = wr; io_addr = a; io_be = be; io_wdata = d;
    @(negedge clk);
    io_valid = 1'b0; io_write = 1'b0; io_be = '0;
  endtask

  // Read of the address port, sampled in the access cycle.
  task automatic rd_cfg(input logic [3:0] be, output logic [31:0] d);
    @(negedge clk);
    io_valid = 1'b1; io_write = 1'b0; io_addr = 16'h0CF8; io_be = be;
    #1 d = io_rdata;
    @(negedge clk);
    io_valid = 1'b0; io_be = '0;
  endtask

  function automatic logic [31:0] mk_cfg(input logic en, input logic [7:0] b,
      input logic [4:0] dv, input logic [2:0] f, input logic [5:0] r);
    return {en, 7'd0, b, dv, f, r, 2'b00};
  endfunction

  initial begin
    #1000000;
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [31:0] rd;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1: reset state
    check("R1 route_valid", {31'd0, route_valid}, 32'd0);
    check("R1 io_pass", {31'd0, io_pass}, 32'd0);
    rd_cfg(4'hF, rd);
    check("R1 reset value", rd, 32'h0);

    // table walk: R4..R8, R10
    for (int i = 0; i < NV; i++) begin
      logic [7:0] b;
      logic [4:0] dv;
      logic [2:0] f;
      logic [5:0] r;
      b = VEC[i][31:24]; dv = VEC[i][23:19];
      f = 3'(i); r = 6'(i * 5 + 1);
      sec_bus = VEC[i][18:11]; sub_bus = VEC[i][10:3];
      io_op(1'b1, 16'h0CF8, 4'hF, mk_cfg(1'b1, b, dv, f, r));
      io_op(1'b0, 16'h0CFC + 16'(i % 4), 4'h1 << (i % 4), 32'h0);
      check("R10 route_valid", {31'd0, route_valid}, 32'd1);
      check("R4-8 route_tgt", {30'd0, route_tgt}, {30'd0, VEC[i][2:1]});
      check("R4-8 route_type1", {31'd0, route_type1}, {31'd0, VEC[i][0]});
      check("R10 fields", {8'd0, route_bus, 3'd0, route_dev, route_fn, 2'd0, route_reg},
            {8'd0, b, 3'd0, dv, f, 2'd0, r});
      check("R8 no pass", {31'd0, io_pass}, 32'd0);
      @(negedge clk);
      check("R10 strobe one cycle", {31'd0, route_valid}, 32'd0);
    end

    // R2: masked write and read-back
    io_op(1'b1, 16'h0CF8, 4'hF, 32'hFFFF_FFFF);
    rd_cfg(4'hF, rd);
    check("R2 mask", rd, 32'h80FF_FFFC);

    // R3: partial write does not update, forwards
    io_op(1'b1, 16'h0CF8, 4'h3, 32'h0000_0000);
    check("R3 io_pass", {31'd0, io_pass}, 32'd1);
    check("R3 pass_addr/be", {12'd0, pass_addr, pass_be}, {12'd0, 16'h0CF8, 4'h3});
    rd_cfg(4'h1, rd);
    check("R3 partial read zero", rd, 32'h0);
    rd_cfg(4'hF, rd);
    check("R3 reg unchanged", rd, 32'h80FF_FFFC);

    // R11: other address
    io_op(1'b1, 16'h0CF4, 4'hF, 32'h0);
    check("R11 no pass", {31'd0, io_pass}, 32'd0);
    check("R11 no route", {31'd0, route_valid}, 32'd0);
    rd_cfg(4'hF, rd);
    check("R11 reg unchanged", rd, 32'h80FF_FFFC);

    // R9: enable clear
    io_op(1'b1, 16'h0CF8, 4'hF, mk_cfg(1'b0, 8'd3, 5'd1, 3'd0, 6'd0));
    io_op(1'b0, 16'h0CFE, 4'h4, 32'h0);
    check("R9 no route", {31'd0, route_valid}, 32'd0);
    check("R9 io_pass", {31'd0, io_pass}, 32'd1);
    check("R9 pass_addr", {16'd0, pass_addr}, {16'd0, 16'h0CFE});
    @(negedge clk);
    check("R9 pass one cycle", {31'd0, io_pass}, 32'd0);

    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule